// File: doc/BRIEF.md
# Overlapping Register Window File

This block is an integer register file for a processor that keeps procedure context in hardware. Software always sees 32 register numbers. Numbers 0 to 7 are globals that every procedure shares. Numbers 8 to 31 are a 24-entry view into a ring of physical windows. The current window pointer picks which window is in view.

Each window owns 16 fresh registers: eight for outgoing arguments and eight for locals. Its eight incoming-argument registers are the same cells as the caller's outgoing group. A call therefore passes arguments without moving any data. A save request moves into a fresh window by decrementing the pointer. A restore request returns by incrementing it. Both steps wrap around the ring.

A second pointer marks the window most recently spilled to memory. Two cases raise a trap flag instead of moving the pointer:

- A save that would land on that window raises an overflow trap.
- A restore that would land on it raises an underflow trap.

A trap handler then uses a direct port to spill or fill one register per cycle, addressed by window and index. It finishes with an acknowledge, which completes the pending move.

Top module: `regwin_file`

## Requirements
- R1: After reset the current pointer is 0, the spilled-window pointer is 1 modulo the window count, and both trap flags are low.
- R2: Register numbers 0–7 name the same storage in every window.
- R3: In window c, register number a (8–31) is stored in the cell that the direct port addresses as window ((16c + a − 8) mod 16N) div 16, index ((16c + a − 8) mod 16N) mod 16.
- R4: Registers 24–31 of window w are registers 8–15 of window w+1 (mod N). After a save, the callee reads the caller's outgoing values on its incoming numbers.
- R5: A save with no trap pending decrements the current pointer modulo N. A restore increments it modulo N. Both are visible on the port after the next clock edge.
- R6: A save whose target window equals the spilled-window pointer leaves both pointers unchanged and sets the overflow flag after the next edge.
- R7: A restore whose target window equals the spilled-window pointer leaves both pointers unchanged and sets the underflow flag after the next edge.
- R8: An acknowledge clears the pending flag. Under overflow it decrements both pointers. Under underflow it increments both pointers.
- R9: While a trap is pending, save, restore and the architectural write port have no effect, and direct-port writes take effect. With no trap pending, direct-port writes have no effect.
- R10: A read of a register being written in the same cycle returns the old value. The new value is seen after the edge.
- R11: With the write enable low, the write port changes nothing.
- R12: When save and restore are requested in the same cycle, the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_data | output | DW | Read port A data (combinational) |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_data | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Architectural write enable |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to a new window (call) |
| restore_req | input | 1 | Return to the previous window |
| cwp | output | 5 | Current window pointer |
| swp | output | 5 | Spilled-window pointer |
| trap_ovf | output | 1 | Overflow trap pending |
| trap_unf | output | 1 | Underflow trap pending |
| trap_ack | input | 1 | Handler done; completes the pending move |
| fix_we | input | 1 | Direct-port write enable (trap only) |
| fix_win | input | 5 | Direct-port window select |
| fix_idx | input | 4 | Direct-port index 0–15 within the window's fresh block |
| fix_wdata | input | DW | Direct-port write data |
| fix_rdata | output | DW | Direct-port read data (combinational) |

## Verification
A wrong pointer shows on `cwp` or `swp` one edge after the save, restore or acknowledge that caused it. It also shows as the wrong cell on the very next read, because every windowed read goes through the pointer.

A mapping error appears as a mismatch between an architectural read and the direct port for the same cell. The same kind of error breaks the caller-to-callee handoff as soon as the first save completes.

A wrong full or empty decision either raises a trap one save too early or moves the pointer onto the spilled window. The next acknowledge then leaves the two pointers equal, which the flags and pointer outputs reveal within the same cycle.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int GLOB_REGS  = 8;
  localparam int FRESH_REGS = 16;

  // one step deeper into the call chain (toward the callee)
  function automatic logic [4:0] win_back(input logic [4:0] w, input int n);
    if (w == 5'd0) return 5'(n - 1);
    return w - 5'd1;
  endfunction

  // one step back toward the caller
  function automatic logic [4:0] win_fwd(input logic [4:0] w, input int n);
    if (int'(w) >= n - 1) return 5'd0;
    return w + 5'd1;
  endfunction

  // architectural register number to flat cell index
  function automatic int arch_to_phys(input logic [4:0] ptr, input logic [4:0] num,
                                      input int n);
    int flat;
    if (int'(num) < GLOB_REGS) return int'(num);
    flat = (int'(ptr) * FRESH_REGS + int'(num) - GLOB_REGS) % (FRESH_REGS * n);
    return GLOB_REGS + flat;
  endfunction

  // window/index pair of the handler port to flat cell index
  function automatic int fix_to_phys(input logic [4:0] w, input logic [3:0] idx,
                                     input int n);
    return GLOB_REGS + (int'(w) % n) * FRESH_REGS + int'(idx);
  endfunction

endpackage

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       save_req,
  input  logic       restore_req,
  input  logic       trap_ack,
  output logic [4:0] cwp,
  output logic [4:0] swp,
  output logic       trap_ovf,
  output logic       trap_unf,
  output logic       trap_pending
);

  localparam logic [4:0] SWP_INIT = 5'(1 % NWIN);

  logic [4:0] cwp_back, cwp_fwd, swp_back, swp_fwd;
  logic       save_go, restore_go, ovf_hit, unf_hit, ovf_done, unf_done;

  assign cwp_back = win_back(cwp, NWIN);
  assign cwp_fwd  = win_fwd(cwp, NWIN);
  assign swp_back = win_back(swp, NWIN);
  assign swp_fwd  = win_fwd(swp, NWIN);

  assign trap_pending = trap_ovf | trap_unf;
  assign save_go      = save_req && !trap_pending;
  assign restore_go   = restore_req && !save_req && !trap_pending;
  assign ovf_hit      = save_go && (cwp_back == swp);
  assign unf_hit      = restore_go && (cwp_fwd == swp);
  assign ovf_done     = trap_ovf && trap_ack;
  assign unf_done     = trap_unf && trap_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp      <= 5'd0;
      swp      <= SWP_INIT;
      trap_ovf <= 1'b0;
      trap_unf <= 1'b0;
    end else if (ovf_done) begin
      swp      <= swp_back;
      cwp      <= cwp_back;
      trap_ovf <= 1'b0;
    end else if (unf_done) begin
      swp      <= swp_fwd;
      cwp      <= cwp_fwd;
      trap_unf <= 1'b0;
    end else if (ovf_hit) begin
      trap_ovf <= 1'b1;
    end else if (unf_hit) begin
      trap_unf <= 1'b1;
    end else if (save_go) begin
      cwp <= cwp_back;
    end else if (restore_go) begin
      cwp <= cwp_fwd;
    end
  end

  // R6
  ptrs_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwp != swp);

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cwp) < NWIN) && (int'(swp) < NWIN));

  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_go && !ovf_hit) |=> (cwp == $past(cwp_back)));

  // R6
  ovf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (trap_ovf && $stable(cwp) && $stable(swp)));

  // R7
  unf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_hit |=> (trap_unf && $stable(cwp) && $stable(swp)));

  // R9
  trap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && !trap_ack) |=> ($stable(cwp) && $stable(swp)));

  // R8
  ack_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_done || unf_done) |=> (!trap_pending && (cwp == $past(swp))));

  // R8
  one_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({trap_ovf, trap_unf}) <= 1);

endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int PW   = 8
) (
  input  logic [4:0]    ptr,
  input  logic [4:0]    num,
  output logic [PW-1:0] phys
);

  always_comb phys = PW'(arch_to_phys(ptr, num, NWIN));

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DW    = 32,
  parameter int PW    = 8,
  parameter int NPHYS = 136
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          fix_we,
  input  logic [PW-1:0] fix_addr,
  input  logic [DW-1:0] fix_wdata,
  input  logic [PW-1:0] ra_addr,
  input  logic [PW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] fix_rdata
);

  logic [DW-1:0] cells [NPHYS];

  always_ff @(posedge clk) begin
    if (we)     cells[waddr]    <= wdata;
    if (fix_we) cells[fix_addr] <= fix_wdata;
  end

  assign ra_data   = cells[ra_addr];
  assign rb_data   = cells[rb_addr];
  assign fix_rdata = cells[fix_addr];

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_sel,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_sel,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          save_req,
  input  logic          restore_req,
  output logic [4:0]    cwp,
  output logic [4:0]    swp,
  output logic          trap_ovf,
  output logic          trap_unf,
  input  logic          trap_ack,
  input  logic          fix_we,
  input  logic [4:0]    fix_win,
  input  logic [3:0]    fix_idx,
  input  logic [DW-1:0] fix_wdata,
  output logic [DW-1:0] fix_rdata
);

  localparam int NPHYS = GLOB_REGS + FRESH_REGS * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NPORT = 3;  // read A, read B, write

  logic          trap_pending;
  logic          arch_we, fix_we_ok;
  logic [PW-1:0] fix_addr;
  logic [4:0]    sel_v  [NPORT];
  logic [PW-1:0] phys_v [NPORT];

  regwin_ctl #(.NWIN(NWIN)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .trap_ack     (trap_ack),
    .cwp          (cwp),
    .swp          (swp),
    .trap_ovf     (trap_ovf),
    .trap_unf     (trap_unf),
    .trap_pending (trap_pending)
  );

  assign sel_v[0] = rd_a_sel;
  assign sel_v[1] = rd_b_sel;
  assign sel_v[2] = wr_sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regwin_xlate #(.NWIN(NWIN), .PW(PW)) u_map (
      .ptr  (cwp),
      .num  (sel_v[p]),
      .phys (phys_v[p])
    );
  end

  assign arch_we   = wr_en && !trap_pending;
  assign fix_we_ok = fix_we && trap_pending;
  assign fix_addr  = PW'(fix_to_phys(fix_win, fix_idx, NWIN));

  regwin_bank #(.DW(DW), .PW(PW), .NPHYS(NPHYS)) u_bank (
    .clk       (clk),
    .we        (arch_we),
    .waddr     (phys_v[2]),
    .wdata     (wr_data),
    .fix_we    (fix_we_ok),
    .fix_addr  (fix_addr),
    .fix_wdata (fix_wdata),
    .ra_addr   (phys_v[0]),
    .rb_addr   (phys_v[1]),
    .ra_data   (rd_a_data),
    .rb_data   (rd_b_data),
    .fix_rdata (fix_rdata)
  );

  // R2
  global_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel < 5'd8) |-> (int'(phys_v[0]) == int'(rd_a_sel)));

  // R4
  window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel >= 5'd8) |-> ((int'(phys_v[0]) >= GLOB_REGS) && (int'(phys_v[0]) < NPHYS)));

endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;

  localparam int NW = 8;
  localparam int DW = 32;

  typedef enum int {K_RA, K_RB, K_CWP, K_SWP, K_OVF, K_UNF, K_FIX} kind_t;
  typedef struct {
    kind_t       kind;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0, fix_win = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, fix_wdata = '0, fix_rdata;
  logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, trap_ack = 1'b0, fix_we = 1'b0;
  logic [4:0]    cwp, swp;
  logic          trap_ovf, trap_unf;
  logic [3:0]    fix_idx = '0;

  int   checks = 0, errors = 0;
  bit   done = 0;
  exp_t exp_q[$];
  event pushed;

  always #4 clk = ~clk;

  regwin_file #(.NWIN(NW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp), .swp(swp), .trap_ovf(trap_ovf), .trap_unf(trap_unf),
    .trap_ack(trap_ack),
    .fix_we(fix_we), .fix_win(fix_win), .fix_idx(fix_idx),
    .fix_wdata(fix_wdata), .fix_rdata(fix_rdata)
  );

  // bench's own view of where a windowed number lives
  function automatic int flat_of(int c, int a);
    return (c * 16 + a - 8) % (16 * NW);
  endfunction

  // monitor: pops expectations and compares with the ports
  initial forever begin
    @(pushed);
    while (exp_q.size() > 0) begin
      exp_t        it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_RA:    act = rd_a_data;
        K_RB:    act = rd_b_data;
        K_CWP:   act = {27'd0, cwp};
        K_SWP:   act = {27'd0, swp};
        K_OVF:   act = {31'd0, trap_ovf};
        K_UNF:   act = {31'd0, trap_unf};
        default: act = fix_rdata;
      endcase
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.req, act, it.val);
      end
    end
  end

  task automatic expect_val(kind_t k, logic [31:0] v, string req);
    exp_t it;
    #0.1;
    it.kind = k; it.val = v; it.req = req;
    exp_q.push_back(it);
    -> pushed;
    #0.1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_sel = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] v, string req);
    rd_a_sel = a;
    expect_val(K_RA, v, req);
  endtask

  task automatic fixrd(int w, int i, logic [31:0] v, string req);
    fix_win = 5'(w); fix_idx = 4'(i);
    expect_val(K_FIX, v, req);
  endtask

  task automatic fixwr(int w, int i, logic [31:0] d);
    fix_we = 1'b1; fix_win = 5'(w); fix_idx = 4'(i); fix_wdata = d;
    @(negedge clk);
    fix_we = 1'b0;
  endtask

  task automatic do_save();
    save_req = 1'b1; @(negedge clk); save_req = 1'b0;
  endtask

  task automatic do_restore();
    restore_req = 1'b1; @(negedge clk); restore_req = 1'b0;
  endtask

  task automatic do_ack();
    trap_ack = 1'b1; @(negedge clk); trap_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      #1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_val(K_CWP, 0, "R1 cwp");
    expect_val(K_SWP, 1, "R1 swp");
    expect_val(K_OVF, 0, "R1 ovf");
    expect_val(K_UNF, 0, "R1 unf");

    // R11 disabled write changes nothing
    wr(3, 32'hA3);
    wr(4, 32'h44);
    wr_en = 1'b0; wr_sel = 5'd4; wr_data = 32'h99;
    @(negedge clk);
    rd(4, 32'h44, "R11 wr_en low");

    // R3 mapping seen through the handler port
    wr(9, 32'h1009);
    wr(20, 32'h2020);
    wr(26, 32'h2626);
    fixrd(flat_of(0, 9) / 16, flat_of(0, 9) % 16, 32'h1009, "R3 out reg");
    fixrd(flat_of(0, 20) / 16, flat_of(0, 20) % 16, 32'h2020, "R3 local reg");
    fixrd(flat_of(0, 26) / 16, flat_of(0, 26) % 16, 32'h2626, "R3 in reg");

    // R4 and R5: caller outs appear as callee ins; pointer wraps 0 -> 7
    wr(8, 32'h5A);
    do_save();
    expect_val(K_CWP, 7, "R5 save wrap");
    rd(24, 32'h5A, "R4 overlap 0->7");
    rd(3, 32'hA3, "R2 global in window 7");
    rd_b_sel = 5'd4;
    expect_val(K_RB, 32'h44, "R2 global on port B");

    for (int k = 0; k < 4; k++) do_save();   // 7 -> 3
    expect_val(K_CWP, 3, "R5 save chain");
    wr(8, 32'h3030);
    do_save();
    expect_val(K_CWP, 2, "R5 save to 2");
    rd(24, 32'h3030, "R4 overlap 3->2");

    // R6 overflow
    do_save();
    expect_val(K_OVF, 1, "R6 ovf flag");
    expect_val(K_CWP, 2, "R6 cwp held");
    expect_val(K_SWP, 1, "R6 swp held");

    // R9 ignored while trapped
    do_save();
    expect_val(K_CWP, 2, "R9 save ignored");
    do_restore();
    expect_val(K_CWP, 2, "R9 restore ignored");
    wr(3, 32'hBAD);
    rd(3, 32'hA3, "R9 arch write blocked");
    fixwr(0, 5, 32'h7777);
    fixrd(0, 5, 32'h7777, "R9 spill write in trap");

    // R8 overflow acknowledge
    do_ack();
    expect_val(K_OVF, 0, "R8 ovf cleared");
    expect_val(K_SWP, 0, "R8 swp back");
    expect_val(K_CWP, 1, "R8 cwp back");

    // R9 handler writes outside a trap are ignored
    fixwr(3, 0, 32'hDEAD);
    fixrd(3, 0, 32'h3030, "R9 spill write no trap");

    // R5 restores then R7 underflow
    for (int k = 0; k < 6; k++) do_restore();  // 1 -> 7
    expect_val(K_CWP, 7, "R5 restore chain");
    do_restore();
    expect_val(K_UNF, 1, "R7 unf flag");
    expect_val(K_CWP, 7, "R7 cwp held");
    expect_val(K_SWP, 0, "R7 swp held");
    do_ack();
    expect_val(K_UNF, 0, "R8 unf cleared");
    expect_val(K_SWP, 1, "R8 swp fwd");
    expect_val(K_CWP, 0, "R8 cwp fwd");

    // R12 save wins over restore
    save_req = 1'b1; restore_req = 1'b1;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    expect_val(K_CWP, 7, "R12 save priority");
    do_restore();
    expect_val(K_CWP, 0, "R5 restore wrap");

    // R10 read-before-write
    rd_a_sel = 5'd3;
    wr_en = 1'b1; wr_sel = 5'd3; wr_data = 32'h333;
    expect_val(K_RA, 32'hA3, "R10 old value same cycle");
    @(negedge clk);
    wr_en = 1'b0;
    expect_val(K_RA, 32'h333, "R10 new value after edge");

    finish_run();
  end

endmodule